// File: doc/BRIEF.md
# Write-Invalidate Page Coherence Directory

This block keeps the coherence metadata for a small set of shared pages used by several requesting nodes. For every page it records which node is the owner, and for every node and page a three-level access right: no access, read-only or read-write. Nodes send read or write requests. The directory answers each request with a grant that says what had to happen before access was allowed. The page contents and the transport between nodes are handled elsewhere. This block only decides which messages must be sent, in what order, and what the metadata becomes afterwards.

The directory handles one request at a time. A read or write that the node's current right already covers is answered locally. A read without a copy obtains a read-only copy from the owner. A write without write permission proceeds in three steps:

1. The directory sends invalidations to every other node that holds a copy.
2. It waits until each of those nodes acknowledges.
3. It hands write permission and ownership to the writer.

Top module: `wi_dir`

## Requirements
- R1: After reset, page p is owned by node (p mod NODES) with read-write right and every other node has no access to it. Outside an invalidation round the owner of a page always holds a copy.
- R2: A read by a node that already has read-only or read-write right on the page produces a grant of kind HIT (0), with from equal to the requester. The grant appears in the cycle after acceptance, with no invalidation and no change of rights.
- R3: A read by a node with no access produces a grant of kind FILL (1), with from equal to the page's current owner. The requester becomes read-only. An owner that held read-write drops to read-only and keeps ownership.
- R4: A write by a node without read-write right starts an invalidation round on the page. From the cycle after acceptance, inv_valid has a bit set for every other node holding a copy, and inv_page carries the page.
- R5: Each invalidation bit stays set until the matching inv_ack is seen, and that node's right becomes no access. The write grant is issued one cycle after the last pending acknowledge, never earlier.
- R6: A completed write makes the writer the owner with read-write right. The grant kind is XFER (3) with from equal to the previous owner when ownership moved, or UPGRADE (2) with from equal to the writer when the writer already owned the page. The previous owner ends with no access.
- R7: A write by a node that already has read-write right produces a HIT (0) grant in the cycle after acceptance, with no invalidation.
- R8: At most one req_ready bit is set. In an idle cycle it goes to the lowest-numbered node with req_valid set, and no request is accepted while an invalidation round is in progress.
- R9: An inv_ack from a node with no pending invalidation has no effect on inv_valid, on rights or on grant timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NODES | Per-node request valid |
| req_write | input | NODES | Per-node operation: 1 write, 0 read |
| req_page | input | NODES*PW | Per-node page id, node i at bits [i*PW +: PW] |
| req_ready | output | NODES | One-hot acceptance of the selected request |
| inv_valid | output | NODES | Pending invalidation per node |
| inv_page | output | PW | Page being invalidated |
| inv_ack | input | NODES | Per-node invalidation acknowledge |
| gnt_valid | output | 1 | One-cycle grant pulse |
| gnt_node | output | NW | Node that receives the grant |
| gnt_page | output | PW | Page of the grant |
| gnt_kind | output | 2 | 0 HIT, 1 FILL, 2 UPGRADE, 3 XFER |
| gnt_from | output | NW | Node the page came from (owner for FILL, previous owner for XFER, requester otherwise) |

## Verification
The assertions assume that every page id presented is below PAGES. They also assume that each node acknowledges a pending invalidation within a bounded time, so that rounds terminate and the idle-time owner check applies. The stimulus draws page ids only from the valid range and holds each request until it is accepted. It raises random acknowledges on every node each cycle, which closes every round within a few cycles and also produces acknowledges from nodes with nothing pending.

// File: rtl/wi_pkg.sv
package wi_pkg;
    typedef enum logic [1:0] {
        MODE_NONE = 2'd0,
        MODE_RD   = 2'd1,
        MODE_RW   = 2'd2
    } mode_e;

    typedef enum logic [1:0] {
        KIND_HIT  = 2'd0,
        KIND_FILL = 2'd1,
        KIND_UPG  = 2'd2,
        KIND_XFER = 2'd3
    } kind_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } st_e;
endpackage

// File: rtl/wi_arb.sv
module wi_arb #(
    parameter int NODES = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      en,
    input  logic [NODES-1:0]          valid,
    output logic [NODES-1:0]          grant,
    output logic [$clog2(NODES)-1:0]  idx,
    output logic                      any
);
    localparam int NW = $clog2(NODES);

    always_comb begin
        idx = '0;
        for (int i = NODES - 1; i >= 0; i--) begin
            if (valid[i]) idx = NW'(i);
        end
        any   = |valid;
        grant = (en && any) ? (NODES'(1) << idx) : '0;
    end

    // lowest-numbered valid requester wins (R8)
    assert_low_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0) |-> ((valid & (grant - NODES'(1))) == '0));

    assert_grant_is_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant & ~valid) == '0));
endmodule

// File: rtl/wi_table.sv
module wi_table
    import wi_pkg::*;
#(
    parameter int NODES = 4,
    parameter int PAGES = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [$clog2(PAGES)-1:0]          rd_page,
    output logic [NODES-1:0][1:0]             rd_modes,
    output logic [$clog2(NODES)-1:0]          rd_owner,
    input  logic                              fill_en,
    input  logic                              clr_en,
    input  logic                              take_en,
    input  logic [$clog2(PAGES)-1:0]          op_page,
    input  logic [$clog2(NODES)-1:0]          op_node,
    input  logic [NODES-1:0]                  clr_mask
);
    localparam int NW = $clog2(NODES);

    typedef struct packed {
        logic [PAGES-1:0][NODES-1:0][1:0] mode;
        logic [PAGES-1:0][NW-1:0]         owner;
    } tab_t;

    tab_t tab_d, tab_q;
    logic [NW-1:0] cur_own;

    always_comb begin
        tab_d   = tab_q;
        cur_own = tab_q.owner[op_page];
        if (fill_en) begin
            tab_d.mode[op_page][op_node] = MODE_RD;
            if (tab_q.mode[op_page][cur_own] == MODE_RW && cur_own != op_node)
                tab_d.mode[op_page][cur_own] = MODE_RD;
        end
        if (clr_en) begin
            for (int i = 0; i < NODES; i++) begin
                if (clr_mask[i]) tab_d.mode[op_page][i] = MODE_NONE;
            end
        end
        if (take_en) begin
            tab_d.mode[op_page][op_node] = MODE_RW;
            tab_d.owner[op_page]         = op_node;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < PAGES; p++) begin
                tab_q.owner[p] <= NW'(p % NODES);
                for (int n = 0; n < NODES; n++) begin
                    tab_q.mode[p][n] <= (n == p % NODES) ? MODE_RW : MODE_NONE;
                end
            end
        end else begin
            tab_q <= tab_d;
        end
    end

    assign rd_modes = tab_q.mode[rd_page];
    assign rd_owner = tab_q.owner[rd_page];

    for (genvar p = 0; p < PAGES; p++) begin : g_pg
        logic [NODES-1:0] rw_bits;
        always_comb begin
            for (int n = 0; n < NODES; n++) rw_bits[n] = (tab_q.mode[p][n] == MODE_RW);
        end
        // at most one writable copy per page (R6)
        assert_single_writer_R6: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(rw_bits) <= 1);
    end
endmodule

// File: rtl/wi_dir.sv
module wi_dir
    import wi_pkg::*;
#(
    parameter int NODES = 4,
    parameter int PAGES = 4,
    localparam int NW = $clog2(NODES),
    localparam int PW = $clog2(PAGES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NODES-1:0]     req_valid,
    input  logic [NODES-1:0]     req_write,
    input  logic [NODES*PW-1:0]  req_page,
    output logic [NODES-1:0]     req_ready,
    output logic [NODES-1:0]     inv_valid,
    output logic [PW-1:0]        inv_page,
    input  logic [NODES-1:0]     inv_ack,
    output logic                 gnt_valid,
    output logic [NW-1:0]        gnt_node,
    output logic [PW-1:0]        gnt_page,
    output logic [1:0]           gnt_kind,
    output logic [NW-1:0]        gnt_from
);
    typedef struct packed {
        st_e              st;
        logic [NODES-1:0] pend;
        logic [NW-1:0]    node;
        logic [PW-1:0]    page;
        logic             gv;
        logic [NW-1:0]    gnode;
        logic [PW-1:0]    gpage;
        kind_e            gkind;
        logic [NW-1:0]    gfrom;
    } ctl_t;

    ctl_t d, q;

    logic                   arb_en, arb_any;
    logic [NODES-1:0]       arb_grant;
    logic [NW-1:0]          arb_idx;
    logic [PW-1:0]          sel_page, lk_page;
    logic [NODES-1:0][1:0]  rd_modes;
    logic [NW-1:0]          rd_owner;
    logic                   t_fill, t_clr, t_take;
    logic [PW-1:0]          t_page;
    logic [NW-1:0]          t_node;
    logic [NODES-1:0]       t_mask;
    logic [NODES-1:0]       holders;
    logic [1:0]             my_mode;
    logic                   my_wr;

    assign arb_en = (q.st == ST_IDLE);

    wi_arb #(.NODES(NODES)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (arb_en),
        .valid (req_valid),
        .grant (arb_grant),
        .idx   (arb_idx),
        .any   (arb_any)
    );

    assign sel_page = req_page[arb_idx*PW +: PW];
    assign lk_page  = (q.st == ST_IDLE) ? sel_page : q.page;

    wi_table #(.NODES(NODES), .PAGES(PAGES)) u_tab (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_page  (lk_page),
        .rd_modes (rd_modes),
        .rd_owner (rd_owner),
        .fill_en  (t_fill),
        .clr_en   (t_clr),
        .take_en  (t_take),
        .op_page  (t_page),
        .op_node  (t_node),
        .clr_mask (t_mask)
    );

    always_comb begin
        for (int i = 0; i < NODES; i++) holders[i] = (rd_modes[i] != MODE_NONE);
    end

    always_comb begin
        d       = q;
        d.gv    = 1'b0;
        t_fill  = 1'b0;
        t_clr   = 1'b0;
        t_take  = 1'b0;
        t_page  = q.page;
        t_node  = q.node;
        t_mask  = '0;
        my_mode = rd_modes[arb_idx];
        my_wr   = req_write[arb_idx];
        case (q.st)
            ST_IDLE: begin
                if (arb_any) begin
                    d.node  = arb_idx;
                    d.page  = sel_page;
                    d.gnode = arb_idx;
                    d.gpage = sel_page;
                    t_page  = sel_page;
                    t_node  = arb_idx;
                    if ((!my_wr && my_mode != MODE_NONE) || (my_wr && my_mode == MODE_RW)) begin
                        d.gv    = 1'b1;
                        d.gkind = KIND_HIT;
                        d.gfrom = arb_idx;
                    end else if (!my_wr) begin
                        t_fill  = 1'b1;
                        d.gv    = 1'b1;
                        d.gkind = KIND_FILL;
                        d.gfrom = rd_owner;
                    end else begin
                        d.pend = holders & ~(NODES'(1) << arb_idx);
                        d.st   = ST_WAIT;
                    end
                end
            end
            ST_WAIT: begin
                if (q.pend == '0) begin
                    t_take  = 1'b1;
                    d.gv    = 1'b1;
                    d.gnode = q.node;
                    d.gpage = q.page;
                    d.gkind = (rd_owner == q.node) ? KIND_UPG : KIND_XFER;
                    d.gfrom = rd_owner;
                    d.st    = ST_IDLE;
                end else begin
                    t_clr  = 1'b1;
                    t_mask = q.pend & inv_ack;
                    d.pend = q.pend & ~inv_ack;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
            q.gkind <= KIND_HIT;
        end else begin
            q <= d;
        end
    end

    assign req_ready = arb_grant;
    assign inv_valid = (q.st == ST_WAIT) ? q.pend : '0;
    assign inv_page  = q.page;
    assign gnt_valid = q.gv;
    assign gnt_node  = q.gnode;
    assign gnt_page  = q.gpage;
    assign gnt_kind  = q.gkind;
    assign gnt_from  = q.gfrom;

    assert_ready_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_ready));

    assert_busy_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_WAIT) |-> (req_ready == '0));

    assert_inv_after_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|inv_valid) |-> $past(|(req_ready & req_write)));

    assert_pend_shrinks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_WAIT && $past(q.st == ST_WAIT)) |-> ((inv_valid & ~$past(inv_valid)) == '0));

    assert_grant_after_acks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid && (gnt_kind == KIND_UPG || gnt_kind == KIND_XFER))
            |-> $past(q.st == ST_WAIT && inv_valid == '0));

    assert_owner_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE) |-> (rd_modes[rd_owner] != MODE_NONE));
endmodule

// File: tb/tb_wi_dir.sv
module tb_wi_dir;
    localparam int N  = 4;
    localparam int P  = 4;
    localparam int NW = 2;
    localparam int PW = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    req_valid = '0, req_write = '0;
    logic [N*PW-1:0] req_page = '0;
    logic [N-1:0]    req_ready, inv_valid, inv_ack = '0;
    logic [PW-1:0]   inv_page, gnt_page;
    logic            gnt_valid;
    logic [NW-1:0]   gnt_node, gnt_from;
    logic [1:0]      gnt_kind;

    always #5 clk = ~clk;

    wi_dir #(.NODES(N), .PAGES(P)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_page(req_page), .req_ready(req_ready), .inv_valid(inv_valid),
        .inv_page(inv_page), .inv_ack(inv_ack), .gnt_valid(gnt_valid),
        .gnt_node(gnt_node), .gnt_page(gnt_page), .gnt_kind(gnt_kind), .gnt_from(gnt_from)
    );

    int nchk = 0, nfail = 0;
    bit done = 0;

    // behavioural reference
    int md [P][N];
    int own [P];
    int m_st, m_n, m_p, m_gv, m_gk, m_gn, m_gp, m_gf;
    logic [N-1:0] m_pend;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int p = 0; p < P; p++) begin
            own[p] = p % N;
            for (int n = 0; n < N; n++) md[p][n] = (n == p % N) ? 2 : 0;
        end
        m_st = 0; m_gv = 0; m_pend = '0;
    endtask

    task automatic set_grant(input int k, input int n, input int p, input int f);
        m_gv = 1; m_gk = k; m_gn = n; m_gp = p; m_gf = f;
    endtask

    task automatic model_step();
        int n, p, o;
        bit w;
        m_gv = 0;
        if (m_st == 0) begin
            n = -1;
            for (int i = 0; i < N; i++) if (req_valid[i] && n < 0) n = i;
            if (n >= 0) begin
                p = int'(req_page[n*PW +: PW]);
                w = req_write[n];
                if ((!w && md[p][n] != 0) || (w && md[p][n] == 2)) set_grant(0, n, p, n);
                else if (!w) begin
                    o = own[p];
                    if (md[p][o] == 2) md[p][o] = 1;
                    md[p][n] = 1;
                    set_grant(1, n, p, o);
                end else begin
                    m_pend = '0;
                    for (int i = 0; i < N; i++) if (i != n && md[p][i] != 0) m_pend[i] = 1'b1;
                    m_st = 1; m_n = n; m_p = p;
                end
            end
        end else begin
            if (m_pend == '0) begin
                o = own[m_p];
                md[m_p][m_n] = 2;
                own[m_p] = m_n;
                set_grant((o == m_n) ? 2 : 3, m_n, m_p, o);
                m_st = 0;
            end else begin
                for (int i = 0; i < N; i++)
                    if (m_pend[i] && inv_ack[i]) begin md[m_p][i] = 0; m_pend[i] = 1'b0; end
            end
        end
    endtask

    task automatic compare();
        logic [N-1:0] er;
        string gt;
        er = '0;
        if (m_st == 0)
            for (int i = N - 1; i >= 0; i--) if (req_valid[i]) er = N'(1) << i;
        check(req_ready === er, "R8 req_ready", int'(req_ready), int'(er));
        check(inv_valid === ((m_st == 1) ? m_pend : '0), "R4 inv_valid", int'(inv_valid),
              int'((m_st == 1) ? m_pend : '0));
        if (m_st == 1 && m_pend != '0) check(inv_page == PW'(m_p), "R4 inv_page", int'(inv_page), m_p);
        check(gnt_valid === 1'(m_gv), "R5 gnt_valid", int'(gnt_valid), m_gv);
        if (m_gv) begin
            gt = (m_gk == 0) ? "R2 grant" : (m_gk == 1) ? "R3 grant" : "R6 grant";
            check(gnt_kind == 2'(m_gk), {gt, " kind"}, int'(gnt_kind), m_gk);
            check(gnt_node == NW'(m_gn), {gt, " node"}, int'(gnt_node), m_gn);
            check(gnt_page == PW'(m_gp), {gt, " page"}, int'(gnt_page), m_gp);
            check(gnt_from == NW'(m_gf), {gt, " from"}, int'(gnt_from), m_gf);
        end
    endtask

    // called just after a falling edge with inputs already driven
    task automatic tick();
        #1;
        compare();
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic put(input int n, input bit w, input int p);
        req_valid[n] = 1'b1;
        req_write[n] = w;
        req_page[n*PW +: PW] = PW'(p);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            done = 1;
            summary();
            $finish;
        end
    end

    logic [N-1:0] hold;

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(gnt_valid == 1'b0 && inv_valid == '0, "R1 reset outputs idle", int'(gnt_valid), 0);
        @(negedge clk);

        // R3: node1 reads page0, owner from reset is node0 (R1)
        put(1, 0, 0); tick(); req_valid = '0;
        check(gnt_valid && gnt_kind == 2'd1, "R3 fill kind", int'(gnt_kind), 1);
        check(gnt_from == 2'd0, "R1 reset owner of page0", int'(gnt_from), 0);
        tick();
        // R2: second read hits
        put(1, 0, 0); tick(); req_valid = '0;
        check(gnt_valid && gnt_kind == 2'd0, "R2 read hit", int'(gnt_kind), 0);
        tick();
        // R4/R5/R9: owner (now read-only) writes page0
        put(0, 1, 0); #1;
        check(req_ready == 4'b0001, "R8 single ready", int'(req_ready), 1);
        tick(); req_valid = '0;
        check(inv_valid == 4'b0010, "R4 invalidate reader", int'(inv_valid), 2);
        inv_ack = 4'b1000; tick();
        check(inv_valid == 4'b0010 && !gnt_valid, "R9 stray ack ignored", int'(inv_valid), 2);
        inv_ack = 4'b0010; tick(); inv_ack = '0;
        check(inv_valid == 4'b0000 && !gnt_valid, "R5 no grant on ack cycle", int'(gnt_valid), 0);
        tick();
        check(gnt_valid && gnt_kind == 2'd2 && gnt_from == 2'd0, "R6 upgrade grant", int'(gnt_kind), 2);
        tick();
        // R6: node2 writes page1 owned by node1
        put(2, 1, 1); tick(); req_valid = '0;
        check(inv_valid == 4'b0010, "R4 invalidate owner", int'(inv_valid), 2);
        inv_ack = 4'b0010; tick(); inv_ack = '0; tick();
        check(gnt_valid && gnt_kind == 2'd3 && gnt_from == 2'd1 && gnt_node == 2'd2,
              "R6 ownership transfer", int'(gnt_kind), 3);
        tick();
        // R7: new owner writes again
        put(2, 1, 1); tick(); req_valid = '0;
        check(gnt_valid && gnt_kind == 2'd0, "R7 write hit", int'(gnt_kind), 0);
        tick();
        // R8: simultaneous requests
        put(3, 0, 2); put(1, 0, 2); #1;
        check(req_ready == 4'b0010, "R8 lowest id wins", int'(req_ready), 2);
        tick(); req_valid[1] = 1'b0;
        tick(); req_valid = '0;
        tick();

        // random traffic, requests held until accepted
        hold = '0;
        for (int c = 0; c < 4000; c++) begin
            for (int i = 0; i < N; i++) begin
                if (!hold[i]) begin
                    req_valid[i] = ($urandom % 3) == 0;
                    req_write[i] = $urandom % 2;
                    req_page[i*PW +: PW] = PW'($urandom % P);
                end
            end
            inv_ack = N'($urandom);
            #1;
            hold = req_valid & ~req_ready;
            compare();
            @(posedge clk);
            model_step();
            @(negedge clk);
        end

        done = 1;
        summary();
        $finish;
    end
endmodule